// File: doc/BRIEF.md
# Dual Down-Counter Timer Block

This block places two independent down-counting timers behind one 4 KB register window. A word-oriented register port (byte address, write enable, write data, combinational read data) reaches either timer through a small address decoder. Read-only identification bytes sit at the top of the window. The two interrupt requests are merged onto a single output line.

Each timer advances only on its own count-enable strobe. The strobes are qualified pulses in the single system clock domain, so the integrator sets each timer's rate, nominally 1 MHz, by how often it pulses that timer's strobe. A timer can run free, reload periodically or fire once. It can divide its strobe by 1, 16 or 256 and work at a 16-bit or 32-bit width.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x00-0x1F reach timer 0 and 0x20-0x3F reach timer 1, and bits [4:2] select a word. Word 0 is the reload value (read/write; a write also sets the count). Word 1 is the live count (read-only; writes are ignored). Word 2 is control. Word 3 is the flag acknowledge (write-only). Word 4 is the raw flag (bit 0). Word 5 is the masked flag (bit 0). Word 6 is the shadow reload. Word 7 reads zero.
- R2: The control word uses these bits: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale (00 and 11 select /1, 01 selects /16, 10 selects /256), bit 1 32-bit width (0 selects 16 bits) and bit 0 one-shot. After reset, control reads 0x20 and every other timer register reads 0.
- R3: The count drops by one per prescaled strobe of the timer's own count-enable input, and only while run is set. A cleared run bit freezes the count, and one timer's strobe never moves the other timer.
- R4: The raw flag sets when a strobe takes the count from 1 to 0.
- R5: A strobe that finds the count at 0 acts by mode. With one-shot set, the count holds at 0. With periodic set and one-shot clear, the count reloads from the reload register. With both clear, the count wraps to 0xFFFF in 16-bit width or 0xFFFFFFFF in 32-bit width.
- R6: A control write restarts the prescaler. With /16 selected, the count first changes on the 16th strobe after that write.
- R7: A write to word 3 clears the raw flag. The masked flag equals the raw flag ANDed with the interrupt enable bit. A write to word 6 changes the reload value without changing the live count.
- R8: Reads at 0xFE0 through 0xFFC return one zero-extended identification byte per word: 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there are ignored.
- R9: Reads of 0xF00, 0xF04 and any other unmapped offset return zero. Writes outside 0x00-0x3F change nothing.
- R10: irq_out is high exactly when either timer's masked flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick0_en | input | 1 | Count-enable strobe for timer 0 |
| tick1_en | input | 1 | Count-enable strobe for timer 1 |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The bench targets the moment the count reaches zero in each mode. A design that wrapped in one-shot mode would fire again. One that reloaded in free-running mode would read the reload value instead of all ones. One that ignored the width bit would return 0xFFFFFFFF where 0xFFFF is due.

It counts strobes across the /16 boundary. An off-by-one prescaler would move the count on the 15th or 17th strobe.

It drives one timer while the other sits idle and checks that the idle count and flag stay put. A shared or swapped strobe shows up there, as does a decoder that ignores bit 5.

It also reads every identification word and writes into unmapped and identification space. A decoder that aliases those offsets onto a timer would corrupt the reload registers.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    // word indices inside one timer window
    localparam logic [IDX_W-1:0] IDX_RELOAD = 3'd0;
    localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ACK    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_RAW    = 3'd4;
    localparam logic [IDX_W-1:0] IDX_MASKED = 3'd5;
    localparam logic [IDX_W-1:0] IDX_SHADOW = 3'd6;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] div_sel;
        logic       wide;
        logic       one_shot;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = 8'h20;

    typedef enum logic [1:0] {
        MODE_FREE,
        MODE_PERIODIC,
        MODE_SINGLE
    } tmr_mode_t;

    function automatic tmr_mode_t mode_of(input tmr_ctrl_t c);
        if (c.one_shot)      return MODE_SINGLE;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input tmr_ctrl_t c);
        return c.wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h04;
            3'd1:    return 8'h18;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dtw_prescaler.sv
module dtw_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick_in,
    input  logic [1:0] div_sel,
    output logic       tick_out
);
    logic [PRE_W-1:0] pre_q;
    logic             hit;

    always_comb begin
        case (div_sel)
            2'b01:   hit = (pre_q[3:0] == 4'hF);
            2'b10:   hit = (pre_q == {PRE_W{1'b1}});
            default: hit = 1'b1;
        endcase
        tick_out = tick_in && hit && !clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else if (tick_in) pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/dtw_timer_core.sv
module dtw_timer_core
    import dtw_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag_masked
);
    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] reload_q, cnt_q, cnt_m, mask;
    logic              raw_q, ptick, load_wr, ctrl_wr, ack_wr, set_flag;
    tmr_mode_t         mode;

    assign mask    = width_mask(ctrl_q);
    assign mode    = mode_of(ctrl_q);
    assign cnt_m   = cnt_q & mask;
    assign load_wr = wr_en && (wr_idx == IDX_RELOAD);
    assign ctrl_wr = wr_en && (wr_idx == IDX_CTRL);
    assign ack_wr  = wr_en && (wr_idx == IDX_ACK);

    dtw_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctrl_wr || !ctrl_q.run),
        .tick_in  (tick_en),
        .div_sel  (ctrl_q.div_sel),
        .tick_out (ptick)
    );

    assign set_flag = ptick && !load_wr && (cnt_m == {{(DATA_W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= '0;
            cnt_q    <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(wr_data[7:0]);
            if (load_wr || (wr_en && wr_idx == IDX_SHADOW)) reload_q <= wr_data;

            if (load_wr) begin
                cnt_q <= wr_data & mask;
            end else if (ptick) begin
                if (cnt_m == '0) begin
                    case (mode)
                        MODE_SINGLE:   cnt_q <= '0;
                        MODE_PERIODIC: cnt_q <= reload_q & mask;
                        default:       cnt_q <= mask;
                    endcase
                end else begin
                    cnt_q <= (cnt_m - 1'b1) & mask;
                end
            end

            if (set_flag)    raw_q <= 1'b1;
            else if (ack_wr) raw_q <= 1'b0;
        end
    end

    assign flag_masked = raw_q && ctrl_q.irq_en;

    always_comb begin
        case (rd_idx)
            IDX_RELOAD, IDX_SHADOW: rd_data = reload_q;
            IDX_COUNT:              rd_data = cnt_m;
            IDX_CTRL:               rd_data = {{(DATA_W-8){1'b0}}, ctrl_q};
            IDX_RAW:                rd_data = {{(DATA_W-1){1'b0}}, raw_q};
            IDX_MASKED:             rd_data = {{(DATA_W-1){1'b0}}, flag_masked};
            default:                rd_data = '0;
        endcase
    end

    // R3: a stopped timer with no register write keeps its count
    a_r3_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !wr_en) |=> $stable(cnt_q));

    // R4: the raw flag only rises together with a zero count
    a_r4_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> (cnt_m == '0));

    // R5: one-shot mode parks at zero
    a_r5_single_parks: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE && cnt_m == '0 && !load_wr && !ctrl_wr) |=> (cnt_m == '0));

    // R7: acknowledge without a concurrent expiry clears the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !set_flag) |=> !raw_q);
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
    import dtw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick0_en,
    input  logic              tick1_en,
    output logic              irq_out
);
    localparam int NT = 2;

    logic [NT-1:0]     ticks, flags;
    logic [DATA_W-1:0] trd [NT];
    logic              in_timers, in_ident;

    assign ticks     = {tick1_en, tick0_en};
    assign in_timers = (bus_addr[ADDR_W-1:6] == '0);
    assign in_ident  = (bus_addr[ADDR_W-1:5] == {(ADDR_W-5){1'b1}});

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        dtw_timer_core #(.PRE_W(PRE_W)) u_core (
            .clk         (clk),
            .rst         (rst),
            .tick_en     (ticks[g]),
            .wr_en       (bus_we && in_timers && (bus_addr[5] == g[0])),
            .wr_idx      (bus_addr[4:2]),
            .wr_data     (bus_wdata),
            .rd_idx      (bus_addr[4:2]),
            .rd_data     (trd[g]),
            .flag_masked (flags[g])
        );
    end

    always_comb begin
        if (in_timers)     bus_rdata = trd[bus_addr[5]];
        else if (in_ident) bus_rdata = {24'h0, ident_byte(bus_addr[4:2])};
        else               bus_rdata = '0;
    end

    assign irq_out = |flags;

    // R8: first identification word
    a_r8_ident_first: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 12'hFE0) |-> (bus_rdata == 32'h04));

    // R9: test-control offsets read zero
    a_r9_test_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 12'hF00 || bus_addr == 12'hF04) |-> (bus_rdata == '0));
endmodule

// File: tb/test_dual_timer_wrap.sv
module test_dual_timer_wrap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick0_en = 1'b0, tick1_en = 1'b0;
    logic        irq_out;
    int          n_chk = 0, n_err = 0;
    logic [7:0]  ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #2.5 clk = ~clk;

    dual_timer_wrap i_dual_timer_wrap (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick0_en(tick0_en), .tick1_en(tick1_en), .irq_out(irq_out));

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_addr = a; #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_err++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string req);
        @(negedge clk); #1;
        n_chk++;
        if (irq_out !== exp) begin
            n_err++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq_out, exp);
        end
    endtask

    task automatic tick(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which == 0) tick0_en = 1'b1; else tick1_en = 1'b1;
            @(negedge clk);
            tick0_en = 1'b0; tick1_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd(12'h008, 32'h20, "R2 ctrl reset");
        rd(12'h028, 32'h20, "R2 ctrl1 reset");
        rd(12'h004, 32'h0, "R2 count reset");
        rd(12'h000, 32'h0, "R2 reload reset");
        irq_chk(1'b0, "R10 reset irq");
    endtask

    task automatic t_periodic;   // R3 R4 R5 R10
        wr(12'h008, 32'hE2);
        wr(12'h000, 32'd3);
        tick(0, 2);
        rd(12'h004, 32'd1, "R3 count after 2");
        rd(12'h010, 32'd0, "R4 raw not yet");
        tick(0, 1);
        rd(12'h004, 32'd0, "R3 count zero");
        rd(12'h010, 32'd1, "R4 raw set");
        irq_chk(1'b1, "R10 irq on");
        tick(0, 1);
        rd(12'h004, 32'd3, "R5 periodic reload");
        wr(12'h00C, 32'h0);
        rd(12'h010, 32'd0, "R7 ack clears");
        irq_chk(1'b0, "R10 irq off");
    endtask

    task automatic t_halt;       // R3 R1
        wr(12'h008, 32'h62);
        tick(0, 3);
        rd(12'h004, 32'd3, "R3 halted count");
        wr(12'h004, 32'h55);
        rd(12'h004, 32'd3, "R1 count write ignored");
    endtask

    task automatic t_free;       // R5 width
        wr(12'h008, 32'hA0);
        wr(12'h000, 32'd1);
        tick(0, 2);
        rd(12'h004, 32'h0000FFFF, "R5 free wrap 16");
        wr(12'h008, 32'hA2);
        wr(12'h000, 32'd1);
        tick(0, 2);
        rd(12'h004, 32'hFFFFFFFF, "R5 free wrap 32");
        wr(12'h00C, 32'h0);
    endtask

    task automatic t_single;     // R5 one-shot
        wr(12'h008, 32'hA1);
        wr(12'h000, 32'd2);
        tick(0, 2);
        rd(12'h010, 32'd1, "R4 one-shot raw");
        wr(12'h00C, 32'h0);
        tick(0, 3);
        rd(12'h004, 32'd0, "R5 one-shot holds");
        rd(12'h010, 32'd0, "R5 one-shot no refire");
    endtask

    task automatic t_prescale;   // R6
        wr(12'h008, 32'hE6);
        wr(12'h000, 32'd2);
        tick(0, 15);
        rd(12'h004, 32'd2, "R6 no move at 15");
        tick(0, 1);
        rd(12'h004, 32'd1, "R6 move at 16");
        wr(12'h008, 32'h20);
    endtask

    task automatic t_mask_shadow; // R7
        wr(12'h008, 32'hC2);
        wr(12'h000, 32'd1);
        tick(0, 1);
        rd(12'h010, 32'd1, "R7 raw set");
        rd(12'h014, 32'd0, "R7 masked low");
        irq_chk(1'b0, "R10 masked irq low");
        wr(12'h008, 32'hE2);
        rd(12'h014, 32'd1, "R7 masked high");
        irq_chk(1'b1, "R10 irq after enable");
        wr(12'h00C, 32'h0);
        wr(12'h018, 32'd7);
        rd(12'h000, 32'd7, "R7 shadow reload");
        rd(12'h004, 32'd0, "R7 shadow keeps count");
        tick(0, 1);
        rd(12'h004, 32'd7, "R7 shadow used at reload");
        wr(12'h008, 32'h20);
    endtask

    task automatic t_second;     // R1 R3 R10
        wr(12'h028, 32'hE2);
        wr(12'h020, 32'd2);
        rd(12'h000, 32'd7, "R1 timer0 reload intact");
        tick(0, 2);
        rd(12'h024, 32'd2, "R3 timer1 ignores tick0");
        tick(1, 2);
        rd(12'h024, 32'd0, "R3 timer1 counts");
        rd(12'h030, 32'd1, "R4 timer1 raw");
        rd(12'h010, 32'd0, "R3 timer0 flag idle");
        irq_chk(1'b1, "R10 irq from timer1");
        wr(12'h02C, 32'h0);
        irq_chk(1'b0, "R10 irq cleared");
    endtask

    task automatic t_map;        // R8 R9
        for (int i = 0; i < 8; i++)
            rd(12'hFE0 + 12'(i * 4), {24'h0, ids[i]}, "R8 ident");
        rd(12'hF00, 32'h0, "R9 test ctrl");
        rd(12'hF04, 32'h0, "R9 test out");
        rd(12'h800, 32'h0, "R9 unmapped");
        rd(12'h01C, 32'h0, "R1 word7 zero");
        wr(12'h100, 32'hDEAD);
        wr(12'h040, 32'hBEEF);
        wr(12'hFE0, 32'h99);
        wr(12'hF00, 32'h1);
        rd(12'h000, 32'd7, "R9 timer0 reload unchanged");
        rd(12'h020, 32'd2, "R9 timer1 reload unchanged");
        rd(12'hFE0, 32'h04, "R8 ident write ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_periodic;
        t_halt;
        t_free;
        t_single;
        t_prescale;
        t_mask_shadow;
        t_second;
        t_map;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule